// File: doc/BRIEF.md
# Residue-Arithmetic FIR Channel

This block computes one lane of a direct-form FIR filter in residue arithmetic. All values belong to a single modulus, either 2^N-1 or 2^N, and a parameter selects which. On every clock it accepts one input residue and pushes it into a tap delay line. It then multiplies each tap by a constant coefficient residue and produces one filtered residue. A full filter places several such channels side by side, one for each modulus of the residue set. Conversion to and from binary happens outside the block.

The block has no separate multiply stage and no accumulator. Each coefficient bit that is set selects a shifted copy of its tap. For modulus 2^N-1 that copy is an end-around rotation; for 2^N it is a truncated shift. All copies from all taps feed one carry-save tree built from plain full adders. Each carry vector is folded back into N bits, so words never grow. A register captures the final sum/carry pair, and one modulo adder resolves it into a registered output.

Top module: `rns_fir_channel`

## Requirements
- R1: The output is always strictly less than the modulus M. M is 2^N-1 when KIND is MOD_MERSENNE (value 0) and 2^N when KIND is MOD_POW2 (value 1).
- R2: Each clock edge shifts the input residue into tap 0. Tap k holds the input captured k edges earlier, so an isolated input of 1 produces the coefficient sequence c_0, c_1, ... on successive outputs.
- R3: The output equals (sum over k of c_k * x[j-k]) mod M. Coefficient c_k is taken from bits [k*N +: N] of COEF_VEC, tap 0 is the newest input, and inputs before reset count as zero.
- R4: The result for the input sampled at edge j appears on y_o after edge j+2 and holds until edge j+3.
- R5: An asynchronous active-low reset clears the taps, the pipeline pair and the output. y_o reads 0 while reset is held, and inputs captured before reset never contribute afterwards.
- R6: For modulus 2^N-1, full-scale inputs (M-1) and coefficients equal to M-1 give correct residues, with a result of M mapped to 0.
- R7: For modulus 2^N, every weight of 2^N and above is discarded, so the output equals the integer convolution mod 2^N.
- R8: After TAPS+2 consecutive zero inputs, the output is 0.
- R9: A constant input v held for TAPS+3 edges or more gives a steady output equal to (v * sum of c_k) mod M.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| x_i | input | N | Input residue, below M |
| y_o | output | N | Filtered residue, registered |

## Verification
The taps, the pair register and the output register are all observable through the convolution. A stale or misordered tap shows up as a wrong output within TAPS+2 cycles of a suitable input. An isolated impulse exposes it as a misplaced coefficient in a single output. A fault in a carry fold or in the final modulo adder corrupts the very next result. Full-scale and random inputs reach the carry paths that small values leave untouched. Long zero and constant runs give the checker simple predictions that hold at every cycle, without a model of the filter.

// File: rtl/rns_fir_pkg.sv
package rns_fir_pkg;

    // Modulus family of a residue channel
    typedef enum logic {
        MOD_MERSENNE = 1'b0,   // 2^N - 1, carries wrap to bit 0
        MOD_POW2     = 1'b1    // 2^N, carries past bit N-1 are dropped
    } mod_kind_e;

    function automatic int unsigned modulus_of(input int unsigned n, input mod_kind_e kind);
        return (kind == MOD_POW2) ? (32'd1 << n) : ((32'd1 << n) - 32'd1);
    endfunction

endpackage

// File: rtl/rns_pp_gen.sv
// Expands every tap against its constant coefficient into weighted copies,
// one per coefficient bit, already reduced into N bits.
module rns_pp_gen
    import rns_fir_pkg::*;
#(
    parameter int unsigned        N        = 5,
    parameter int unsigned        TAPS     = 8,
    parameter mod_kind_e          KIND     = MOD_MERSENNE,
    parameter logic [TAPS*N-1:0]  COEF_VEC = '0
) (
    input  logic [TAPS-1:0][N-1:0]   taps_i,
    output logic [TAPS*N-1:0][N-1:0] terms_o
);

    for (genvar k = 0; k < TAPS; k++) begin : g_tap
        for (genvar j = 0; j < N; j++) begin : g_bit
            localparam bit SEL = COEF_VEC[k*N + j];
            if (!SEL) begin : g_off
                assign terms_o[k*N + j] = '0;
            end else if (j == 0) begin : g_unit
                assign terms_o[k*N + j] = taps_i[k];
            end else if (KIND == MOD_MERSENNE) begin : g_rot
                // 2^(N+m) == 2^m modulo 2^N-1: rotate left by j
                assign terms_o[k*N + j] = {taps_i[k][N-1-j:0], taps_i[k][N-1:N-j]};
            end else begin : g_shl
                assign terms_o[k*N + j] = {taps_i[k][N-1-j:0], {j{1'b0}}};
            end
        end
    end

endmodule

// File: rtl/rns_csa_tree.sv
// Carry-save reduction of TERMS words to a sum/carry pair, each N bits.
// Compressor i takes nodes 3i..3i+2 and appends two nodes; processing the
// node list in order yields a breadth-first (Wallace-like) tree.
module rns_csa_tree
    import rns_fir_pkg::*;
#(
    parameter int unsigned N     = 5,
    parameter int unsigned TERMS = 40,
    parameter mod_kind_e   KIND  = MOD_MERSENNE
) (
    input  logic [TERMS-1:0][N-1:0] terms_i,
    output logic [N-1:0]            sum_o,
    output logic [N-1:0]            carry_o
);

    localparam int unsigned CSAS  = TERMS - 2;
    localparam int unsigned NODES = TERMS + 2*CSAS;

    logic [N-1:0] node [NODES];

    for (genvar t = 0; t < TERMS; t++) begin : g_leaf
        assign node[t] = terms_i[t];
    end

    for (genvar i = 0; i < CSAS; i++) begin : g_csa
        logic [N-1:0] a_w, b_w, c_w;
        assign a_w = node[3*i];
        assign b_w = node[3*i + 1];
        assign c_w = node[3*i + 2];
        assign node[TERMS + 2*i] = a_w ^ b_w ^ c_w;
        if (KIND == MOD_MERSENNE) begin : g_wrap
            logic [N-1:0] maj_w;
            assign maj_w = (a_w & b_w) | (a_w & c_w) | (b_w & c_w);
            // carry out of bit N-1 has weight 2^N == 1: wrap to bit 0
            assign node[TERMS + 2*i + 1] = {maj_w[N-2:0], maj_w[N-1]};
        end else begin : g_drop
            logic [N-2:0] maj_w;
            assign maj_w = (a_w[N-2:0] & b_w[N-2:0]) | (a_w[N-2:0] & c_w[N-2:0])
                         | (b_w[N-2:0] & c_w[N-2:0]);
            assign node[TERMS + 2*i + 1] = {maj_w, 1'b0};
        end
    end

    assign sum_o   = node[NODES-2];
    assign carry_o = node[NODES-1];

endmodule

// File: rtl/rns_mod_add.sv
// Resolves a carry-save pair into a canonical residue below the modulus.
module rns_mod_add
    import rns_fir_pkg::*;
#(
    parameter int unsigned N    = 5,
    parameter mod_kind_e   KIND = MOD_MERSENNE
) (
    input  logic [N-1:0] a_i,
    input  logic [N-1:0] b_i,
    output logic [N-1:0] r_o
);

    if (KIND == MOD_MERSENNE) begin : g_mer
        logic [N:0]   raw_w;
        logic [N-1:0] fold_w;
        assign raw_w  = {1'b0, a_i} + {1'b0, b_i};
        assign fold_w = raw_w[N-1:0] + {{(N-1){1'b0}}, raw_w[N]};
        // all-ones is the second code for zero: map it to zero
        assign r_o    = (fold_w == {N{1'b1}}) ? '0 : fold_w;
    end else begin : g_pw2
        assign r_o = a_i + b_i;
    end

endmodule

// File: rtl/rns_fir_channel.sv
module rns_fir_channel
    import rns_fir_pkg::*;
#(
    parameter int unsigned       N        = 5,
    parameter int unsigned       TAPS     = 8,
    parameter mod_kind_e         KIND     = MOD_MERSENNE,
    parameter logic [TAPS*N-1:0] COEF_VEC = {5'd30, 5'd2, 5'd6, 5'd11, 5'd13, 5'd9, 5'd4, 5'd1}
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] x_i,
    output logic [N-1:0] y_o
);

    localparam int unsigned TERMS = TAPS * N;

    typedef struct packed {
        logic [TAPS-1:0][N-1:0] taps;
        logic [N-1:0]           ps;     // pipelined carry-save sum
        logic [N-1:0]           pc;     // pipelined carry-save carry
        logic [N-1:0]           y;
    } state_t;

    state_t st_d, st_q;

    logic [TERMS-1:0][N-1:0] terms_w;
    logic [N-1:0]            tree_sum_w, tree_carry_w, res_w;

    rns_pp_gen #(
        .N(N), .TAPS(TAPS), .KIND(KIND), .COEF_VEC(COEF_VEC)
    ) i_pp (
        .taps_i (st_q.taps),
        .terms_o(terms_w)
    );

    rns_csa_tree #(
        .N(N), .TERMS(TERMS), .KIND(KIND)
    ) i_tree (
        .terms_i(terms_w),
        .sum_o  (tree_sum_w),
        .carry_o(tree_carry_w)
    );

    rns_mod_add #(
        .N(N), .KIND(KIND)
    ) i_add (
        .a_i(st_q.ps),
        .b_i(st_q.pc),
        .r_o(res_w)
    );

    always_comb begin
        st_d         = st_q;
        st_d.taps[0] = x_i;
        for (int k = 1; k < TAPS; k++) begin
            st_d.taps[k] = st_q.taps[k-1];
        end
        st_d.ps = tree_sum_w;
        st_d.pc = tree_carry_w;
        st_d.y  = res_w;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign y_o = st_q.y;

endmodule

// File: rtl/rns_fir_channel_chk.sv
module rns_fir_channel_chk
    import rns_fir_pkg::*;
#(
    parameter int unsigned N    = 5,
    parameter int unsigned TAPS = 8,
    parameter mod_kind_e   KIND = MOD_MERSENNE
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] x_i,
    input logic [N-1:0] y_o
);

    localparam int unsigned MODV = modulus_of(N, KIND);
    localparam int unsigned LIM  = TAPS + 3;

    int unsigned  zero_run, same_run;
    logic [N-1:0] last_x;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zero_run <= 0;
            same_run <= 0;
            last_x   <= '0;
        end else begin
            if (x_i == '0) zero_run <= (zero_run < LIM) ? zero_run + 1 : zero_run;
            else           zero_run <= 0;
            if (x_i == last_x) same_run <= (same_run < LIM) ? same_run + 1 : same_run;
            else               same_run <= 1;
            last_x <= x_i;
        end
    end

    p_out_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        32'(y_o) < MODV);

    p_reset_clear_r5: assert property (@(posedge clk)
        !rst_n |-> (y_o == '0));

    p_zero_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_run >= TAPS + 2) |-> (y_o == '0));

    p_const_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (same_run >= TAPS + 3) |-> $stable(y_o));

endmodule

bind rns_fir_channel rns_fir_channel_chk #(.N(N), .TAPS(TAPS), .KIND(KIND)) i_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .x_i  (x_i),
    .y_o  (y_o)
);

// File: tb/test_rns_fir_channel.sv
`timescale 1ns/1ps
module test_rns_fir_channel;
    import rns_fir_pkg::*;

    localparam int MA = 31;
    localparam int MB = 16;
    localparam int CA [8] = '{1, 4, 9, 13, 11, 6, 2, 30};
    localparam int CB [5] = '{3, 15, 8, 1, 10};
    localparam int HMAX = 2048;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [4:0] xa = '0;
    logic [3:0] xb = '0;
    logic [4:0] ya;
    logic [3:0] yb;

    int total = 0;
    int bad = 0;
    int cnt = 0;
    int ha [HMAX];
    int hb [HMAX];
    bit done = 1'b0;

    always #5 clk = ~clk;

    rns_fir_channel #(
        .N(5), .TAPS(8), .KIND(MOD_MERSENNE),
        .COEF_VEC({5'd30, 5'd2, 5'd6, 5'd11, 5'd13, 5'd9, 5'd4, 5'd1})
    ) i_rns_fir_channel (
        .clk(clk), .rst_n(rst_n), .x_i(xa), .y_o(ya)
    );

    rns_fir_channel #(
        .N(4), .TAPS(5), .KIND(MOD_POW2),
        .COEF_VEC({4'd10, 4'd1, 4'd8, 4'd15, 4'd3})
    ) i_rns_fir_channel_p2 (
        .clk(clk), .rst_n(rst_n), .x_i(xb), .y_o(yb)
    );

    function automatic int exp_a(input int j);
        int acc = 0;
        if (j < 0) return 0;
        for (int k = 0; k < 8; k++) if (j - k >= 0) acc += CA[k] * ha[j-k];
        return acc % MA;
    endfunction

    function automatic int exp_b(input int j);
        int acc = 0;
        if (j < 0) return 0;
        for (int k = 0; k < 5; k++) if (j - k >= 0) acc += CB[k] * hb[j-k];
        return acc % MB;
    endfunction

    task automatic chk(input string req, input int act, input int expv);
        total++;
        if (act != expv) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    // One cycle: check both outputs against the model (3 iterations of
    // latency, R4), then drive the next inputs.
    task automatic step(input int va, input int vb, input string req);
        @(negedge clk);
        chk({req, " mersenne"}, int'(ya), exp_a(cnt - 3));
        chk({req, " pow2"},     int'(yb), exp_b(cnt - 3));
        chk("R1 range", int'(ya) < MA, 1);
        xa = 5'(va);
        xb = 4'(vb);
        ha[cnt] = va;
        hb[cnt] = vb;
        cnt++;
    endtask

    initial begin
        int seed;
        int sa, sb;
        seed = int'($urandom(32'd9137));
        xa = '0; xb = '0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        // R5: reset state
        chk("R5 reset ya", int'(ya), 0);
        chk("R5 reset yb", int'(yb), 0);
        rst_n = 1'b1;
        cnt = 0;

        // R2 R4: isolated impulse exposes tap order and latency
        step(1, 1, "R2 R4 impulse");
        for (int i = 0; i < 12; i++) step(0, 0, "R2 R4 impulse tail");

        // R6 R9: full-scale constant run
        for (int i = 0; i < 16; i++) step(MA - 1, MB - 1, "R6 full scale");
        @(negedge clk);
        sa = 0; sb = 0;
        for (int k = 0; k < 8; k++) sa += CA[k];
        for (int k = 0; k < 5; k++) sb += CB[k];
        chk("R9 constant mersenne", int'(ya), ((MA - 1) * sa) % MA);
        chk("R9 constant pow2",     int'(yb), ((MB - 1) * sb) % MB);
        ha[cnt] = MA - 1; hb[cnt] = MB - 1; cnt++;

        // R8: zero run flushes the line
        for (int i = 0; i < 10; i++) step(0, 0, "R8 zero run");
        @(negedge clk);
        chk("R8 flushed mersenne", int'(ya), 0);
        chk("R8 flushed pow2",     int'(yb), 0);
        ha[cnt] = 0; hb[cnt] = 0; cnt++;

        // alternating extremes
        for (int i = 0; i < 20; i++)
            step((i % 2) ? MA - 1 : 0, (i % 2) ? MB - 1 : 0, "R6 R7 alternating");

        // R3 R7: random residues
        for (int i = 0; i < 600; i++)
            step(int'($urandom % MA), int'($urandom % MB), "R3 R7 random");

        // R5: mid-run reset with a full line
        for (int i = 0; i < 8; i++) step(MA - 2, MB - 3, "R3 preload");
        @(negedge clk);
        rst_n = 1'b0;
        xa = '0; xb = '0;
        #1;
        chk("R5 async clear ya", int'(ya), 0);
        chk("R5 async clear yb", int'(yb), 0);
        @(negedge clk);
        chk("R5 held ya", int'(ya), 0);
        rst_n = 1'b1;
        cnt = 0;
        step(2, 5, "R5 after reset");
        for (int i = 0; i < 12; i++) step(0, 0, "R5 after reset");
        for (int i = 0; i < 40; i++)
            step(int'($urandom % MA), int'($urandom % MB), "R3 R7 random tail");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #1ms;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule